// File: doc/BRIEF.md
# Converter Control Register with Clock Prescaler

This block holds the 16-bit configuration word of a queued analog-to-digital sequencer and turns it into the signals the rest of the converter needs. A seven-bit divider field sets the converter clock. The block produces that clock as a 50% duty square wave and as a one-cycle enable pulse, one pulse per converter clock period. A single assignment bit selects which of two asynchronous external trigger inputs feeds which of two conversion queues. A mode bit selects external multiplexing, and when it is set the block enables the outputs of the two-bit multiplexer address pins.

Software reaches the word through a 16-bit write-data bus with two byte enables and a read-data bus that always shows the current value. Each byte lane can be written on its own. The high half of the word sits at the lower byte address. The trigger inputs pass through a synchronizer and an edge detector, so each rising edge becomes exactly one strobe on the selected queue. A new divider value takes effect only at the end of the current half period. This means the converter clock never has a shortened phase.

Top module: `conv_ctrl_reg`

## Requirements
- R1: After reset, busRData reads 0x0013, extMuxMode and muxAddrOe are 0, and the converter clock period is 40 system cycles.
- R2: busByteEn[0] strobes the lower-address byte, which carries bits 15:8 from busWData[15:8]. busByteEn[1] strobes bits 7:0 from busWData[7:0]. A write with only one enable set leaves the other byte unchanged.
- R3: Bits 14:13 and 11:7 always read as 0, whatever data is written to them.
- R4: Bit 15 is the external multiplexing mode. extMuxMode and muxAddrOe both equal bit 15 (1 = external mode with the address pins driven, 0 = internal mode).
- R5: With divider field value f (1..127), convClkEn is high for exactly one cycle in every 2*(f+1) system cycles.
- R6: Writing 0 to the divider field reads back as 1 in bits 6:0, and the converter clock period is then 2 cycles.
- R7: convClk is a square wave that is high for f+1 cycles and low for f+1 cycles. convClkEn is asserted in the cycle where convClk has just fallen.
- R8: A new divider value is applied only at the end of the half period in progress. That half period completes with the old length, and the next half period uses the new length.
- R9: With bit 12 = 0, a rising edge on extTrig[0] pulses queue1Trig and a rising edge on extTrig[1] pulses queue2Trig.
- R10: With bit 12 = 1, extTrig[0] pulses queue2Trig and extTrig[1] pulses queue1Trig.
- R11: Each rising trigger edge gives exactly one strobe, one cycle long, no matter how long the input stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| busWrEn | input | 1 | Write strobe |
| busByteEn | input | 2 | Byte enables: [0] bits 15:8 (lower address), [1] bits 7:0 |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Current register value |
| extTrig | input | 2 | Asynchronous external trigger inputs |
| queue1Trig | output | 1 | One-cycle trigger strobe for queue 1 |
| queue2Trig | output | 1 | One-cycle trigger strobe for queue 2 |
| convClkEn | output | 1 | One-cycle enable, once per converter clock period |
| convClk | output | 1 | Converter clock, 50% duty |
| extMuxMode | output | 1 | External multiplexing mode flag |
| muxAddrOe | output | 1 | Output enable for the two multiplexer address pins |

## Verification
A corrupted prescaler counter or latched terminal value shows up as a wrong pulse spacing or an uneven high/low split on convClk. This is visible within one converter period, at most 256 cycles. A bad byte-lane decode or reserved-bit mask shows on busRData in the cycle after the write. A swapped or stuck trigger path shows as a strobe on the wrong queue, or a strobe of the wrong width, three cycles after the input edge.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  localparam int DIV_W = 7;
  localparam int REG_W = 16;
  localparam int TRIG_N = 2;

  // bit positions software and the sequencer rely on
  localparam int MODE_BIT = 15;
  localparam int SWAP_BIT = 12;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic [TRIG_N-1:0] trigRise;
    logic              trigSwap;
    logic [DIV_W-1:0]  divField;
  } ctlStrobe_t;
endpackage

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs
  import conv_ctrl_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0] RST_DIV    = 7'd19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busByteEn,
  input  logic [REG_W-1:0]  busWData,
  output logic [REG_W-1:0]  busRData,
  input  logic [TRIG_N-1:0] extTrig,
  output ctlStrobe_t        ctl,
  output logic              modeExt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             modeQ;
  logic             swapQ;
  logic [DIV_W-1:0] divQ;
  logic             unusedWrBits;

  assign unusedWrBits = ^{busWData[14:13], busWData[11:DIV_W]};

  // lane 0 is the lower byte address and holds the upper half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      swapQ <= 1'b0;
      divQ  <= RST_DIV;
    end else if (busWrEn) begin
      if (busByteEn[0]) begin
        modeQ <= busWData[MODE_BIT];
        swapQ <= busWData[SWAP_BIT];
      end
      if (busByteEn[1]) begin
        divQ <= busWData[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    busRData            = '0;
    busRData[MODE_BIT]  = modeQ;
    busRData[SWAP_BIT]  = swapQ;
    busRData[DIV_W-1:0] = (divQ == '0) ? DIV_W'(1) : divQ;
  end

  // trigger synchronizer chain
  logic [SYNC_STAGES-1:0][TRIG_N-1:0] syncQ;
  logic [TRIG_N-1:0]                  prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= extTrig;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ[LAST];
  end

  always_comb begin
    ctl.trigRise = syncQ[LAST] & ~prevQ;
    ctl.trigSwap = swapQ;
    ctl.divField = divQ;
  end

  assign modeExt = modeQ;
endmodule

// File: rtl/conv_ctrl_dp.sv
module conv_ctrl_dp
  import conv_ctrl_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 7'd19
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       convClkEn,
  output logic       convClk,
  output logic       q1Trig,
  output logic       q2Trig
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] term;
  logic             phase;
  logic             hit;
  logic             enQ;

  assign hit = (cnt == term);

  // half period of term+1 cycles; term reloads only at a boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      term  <= RST_DIV;
      phase <= 1'b0;
      enQ   <= 1'b0;
    end else begin
      enQ <= hit & phase;
      if (hit) begin
        cnt   <= '0;
        phase <= ~phase;
        term  <= ctl.divField;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign convClkEn = enQ;
  assign convClk   = phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q1Trig <= 1'b0;
      q2Trig <= 1'b0;
    end else begin
      q1Trig <= ctl.trigSwap ? ctl.trigRise[1] : ctl.trigRise[0];
      q2Trig <= ctl.trigSwap ? ctl.trigRise[0] : ctl.trigRise[1];
    end
  end
endmodule

// File: rtl/conv_ctrl_reg.sv
module conv_ctrl_reg
  import conv_ctrl_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0] RST_DIV    = 7'd19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busByteEn,
  input  logic [REG_W-1:0]  busWData,
  output logic [REG_W-1:0]  busRData,
  input  logic [TRIG_N-1:0] extTrig,
  output logic              queue1Trig,
  output logic              queue2Trig,
  output logic              convClkEn,
  output logic              convClk,
  output logic              extMuxMode,
  output logic              muxAddrOe
);
  ctlStrobe_t ctl;
  logic       modeExt;

  conv_ctrl_regs #(.SYNC_STAGES(SYNC_STAGES), .RST_DIV(RST_DIV)) regs_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busByteEn(busByteEn),
    .busWData(busWData), .busRData(busRData), .extTrig(extTrig),
    .ctl(ctl), .modeExt(modeExt)
  );

  conv_ctrl_dp #(.RST_DIV(RST_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .convClkEn(convClkEn),
    .convClk(convClk), .q1Trig(queue1Trig), .q2Trig(queue2Trig)
  );

  assign extMuxMode = modeExt;
  assign muxAddrOe  = modeExt;
endmodule

// File: rtl/conv_ctrl_reg_chk.sv
module conv_ctrl_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [1:0]  busByteEn,
  input logic [15:0] busWData,
  input logic [15:0] busRData,
  input logic [1:0]  extTrig,
  input logic        queue1Trig,
  input logic        queue2Trig,
  input logic        convClkEn,
  input logic        convClk,
  input logic        extMuxMode,
  input logic        muxAddrOe
);
  p_lane_isolated_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busByteEn == 2'b01) |=> busRData[7:0] == $past(busRData[7:0]));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    busRData[14:13] == 2'b00 && busRData[11:7] == 5'd0);

  p_mode_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    extMuxMode == busRData[15] && muxAddrOe == busRData[15]);

  p_en_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    convClkEn |=> !convClkEn);

  p_field_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    busRData[6:0] != 7'd0);

  p_en_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    convClkEn |-> (!convClk && $past(convClk)));

  p_q1_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    queue1Trig |=> !queue1Trig);

  p_q2_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    queue2Trig |=> !queue2Trig);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({queue1Trig, queue2Trig}) || $past(extTrig) == 2'b11);
endmodule

bind conv_ctrl_reg conv_ctrl_reg_chk chk_i (.*);

// File: tb/conv_ctrl_reg_tb_top.sv
module conv_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busByteEn = 2'b00;
  logic [15:0] busWData = 16'h0000;
  logic [15:0] busRData;
  logic [1:0]  extTrig = 2'b00;
  logic        queue1Trig, queue2Trig, convClkEn, convClk, extMuxMode, muxAddrOe;

  int checks = 0;
  int fails = 0;
  longint cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busByteEn(busByteEn),
    .busWData(busWData), .busRData(busRData), .extTrig(extTrig),
    .queue1Trig(queue1Trig), .queue2Trig(queue2Trig), .convClkEn(convClkEn),
    .convClk(convClk), .extMuxMode(extMuxMode), .muxAddrOe(muxAddrOe)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] en, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busByteEn = en; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 2'b00;
  endtask

  task automatic waitPulse(output longint at);
    at = -1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (convClkEn) begin at = cyc; break; end
    end
  endtask

  // pulse spacing, pulse width and duty for the current field
  task automatic measureClock(input string req, input int f);
    longint t0, t1;
    int hi, lo;
    for (int k = 0; k < 3; k++) waitPulse(t0);
    @(negedge clk);
    check({req, " enable width"}, convClkEn, (f == 0) ? 0 : 0);
    waitPulse(t1);
    check({req, " period"}, t1 - t0, 2 * (f + 1));
    while (!convClk) @(negedge clk);
    hi = 0;
    while (convClk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!convClk) begin lo++; @(negedge clk); end
    check({req, " R7 high"}, hi, f + 1);
    check({req, " R7 low"}, lo, f + 1);
  endtask

  task automatic testReset();
    check("R1 readback", busRData, 16'h0013);
    check("R1 mode", extMuxMode, 0);
    check("R1 oe", muxAddrOe, 0);
    measureClock("R1", 19);
  endtask

  task automatic testLanes();
    writeReg(2'b01, 16'hFFFF);
    @(negedge clk);
    check("R2 upper lane only / R3", busRData, 16'h9013);
    check("R4 mode set", extMuxMode, 1);
    check("R4 oe set", muxAddrOe, 1);
    writeReg(2'b10, 16'h00FF);
    @(negedge clk);
    check("R3 bit7 reserved", busRData, 16'h907F);
    writeReg(2'b10, 16'hFF05);
    @(negedge clk);
    check("R2 lower lane only", busRData, 16'h9005);
    writeReg(2'b01, 16'h0000);
    @(negedge clk);
    check("R4 mode clear", {extMuxMode, muxAddrOe, busRData}, 18'h00005);
  endtask

  task automatic testPeriods();
    writeReg(2'b11, 16'h0000);
    @(negedge clk);
    check("R6 zero reads one", busRData, 16'h0001);
    measureClock("R6", 0);
    writeReg(2'b10, 16'h0001);
    measureClock("R5 f=1", 1);
    writeReg(2'b10, 16'h0013);
    measureClock("R5 f=19", 19);
    writeReg(2'b10, 16'h007F);
    measureClock("R5 f=127", 127);
  endtask

  task automatic testSwitch();
    int hi, lo, n;
    writeReg(2'b10, 16'h0013);
    measureClock("R8 settle", 19);
    @(negedge clk);
    while (convClk) @(negedge clk);
    while (!convClk) @(negedge clk);
    hi = 0; n = 0;
    while (convClk) begin
      hi++; n++;
      if (n == 3) begin busWrEn = 1'b1; busByteEn = 2'b10; busWData = 16'h0003; end
      else begin busWrEn = 1'b0; busByteEn = 2'b00; end
      @(negedge clk);
    end
    busWrEn = 1'b0; busByteEn = 2'b00;
    lo = 0;
    while (!convClk) begin lo++; @(negedge clk); end
    check("R8 half in progress keeps old", hi, 20);
    check("R8 next half uses new", lo, 4);
  endtask

  task automatic trigCount(input logic [1:0] pin, input int hold, output int c1, output int c2);
    c1 = 0; c2 = 0;
    @(negedge clk);
    extTrig = pin;
    for (int i = 0; i < hold + 8; i++) begin
      @(negedge clk);
      if (i == hold - 1) extTrig = 2'b00;
      c1 += queue1Trig; c2 += queue2Trig;
    end
  endtask

  task automatic testTriggers();
    int c1, c2;
    writeReg(2'b01, 16'h0000);
    trigCount(2'b01, 4, c1, c2);
    check("R9 trig0 to q1", {c1[3:0], c2[3:0]}, 8'h10);
    trigCount(2'b10, 4, c1, c2);
    check("R9 trig1 to q2", {c1[3:0], c2[3:0]}, 8'h01);
    writeReg(2'b01, 16'h1000);
    trigCount(2'b01, 4, c1, c2);
    check("R10 trig0 to q2", {c1[3:0], c2[3:0]}, 8'h01);
    trigCount(2'b10, 4, c1, c2);
    check("R10 trig1 to q1", {c1[3:0], c2[3:0]}, 8'h10);
    trigCount(2'b10, 20, c1, c2);
    check("R11 long hold one strobe", {c1[3:0], c2[3:0]}, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLanes();
    testPeriods();
    testSwitch();
    testTriggers();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule